// File: doc/BRIEF.md
# Half-Bridge Deadtime Generator

This block turns a single PWM input into a pair of complementary gate enables for a half-bridge. The high-side enable follows the PWM level in phase and the low-side enable is its inverse. Every time the PWM level changes, both enables are held low for a non-overlap interval before the newly selected side turns on. There is no separate low-side command input.

A 3-bit mode code serves two purposes. It selects one of four deadtime presets, and its zero value requests shutdown. A supply-good input also gates both outputs. Each preset is given in nanoseconds and converted at elaboration into a whole number of clock cycles from the clock rate parameter. With the default 200 MHz clock, the 15, 25, 35 and 45 ns presets become 3, 5, 7 and 9 cycles. At 1 MHz switching this still leaves about 100 cycles per half period.

The control is a five-state machine:

- ST_OFF: both enables low, entered on shutdown or supply loss.
- ST_DEAD_HI: both low, counting down before the high side turns on.
- ST_HI_ON: high side on.
- ST_DEAD_LO: both low, counting down before the low side turns on.
- ST_LO_ON: low side on.

The transitions are:

- Any state goes to ST_OFF while halted (shutdown or supply lost).
- ST_OFF goes to ST_DEAD_HI or ST_DEAD_LO when released, following the PWM level.
- ST_LO_ON goes to ST_DEAD_HI on a PWM rise. ST_HI_ON goes to ST_DEAD_LO on a PWM fall.
- A dead state goes to its ON state when the timer expires with PWM unchanged.
- A dead state goes to the opposite dead state, with the timer reloaded, when PWM reverses.

Top module: `hb_deadtime_gen`

## Requirements
- R1: While rst_n is low, both hs_en and ls_en are 0.
- R2: In steady state, hs_en equals pwm_in and ls_en equals its complement. hs_en is never 1 unless PWM was 1 at the previous clock edge, and ls_en is never 1 unless PWM was 0 there.
- R3: A PWM change sampled at clock edge k turns the conducting output off at edge k. The other output turns on at edge k+N, where N is the selected preset's cycle count. This applies in both directions.
- R4: mode_sel codes map to presets as follows: 1 selects 15 ns, 2 selects 25 ns, 3 selects 35 ns, and 4 to 7 select 45 ns. The cycle count is round(ns × CLK_MHZ / 1000), with a minimum of 1. The defaults give 3, 5, 7 and 9 cycles.
- R5: mode_sel = 0 is shutdown. Both outputs are low from the next clock edge and stay low for as long as the code is 0, regardless of PWM.
- R6: supply_ok = 0 forces both outputs low from the next clock edge and keeps them low.
- R7: After reset, shutdown release, or supply_ok returning high, the side chosen by PWM turns on only after a full N-cycle interval with both outputs low.
- R8: A mode change has no effect on the outputs until the next PWM change. The preset latched when a deadtime interval starts governs that whole interval.
- R9: If PWM reverses during a deadtime interval, the pending turn-on is cancelled. A fresh full interval is counted from the reversal edge for the opposite side.
- R10: hs_en and ls_en are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock; deadtime is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | PWM command; 1 requests the high side |
| mode_sel | input | 3 | 0 = shutdown; 1/2/3 = short/mid/long preset; 4..7 = longest preset |
| supply_ok | input | 1 | Supply-good flag; 0 disables both outputs |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |

## Verification
The bench counts the exact length of every non-overlap gap for all preset codes, including the codes above 4. A design that used the wrong count, or counted one cycle short or long, would turn on early or late. The bench changes the mode code in the middle of an ON phase and in the middle of a deadtime interval. A design reading the live code would stretch or shorten the running interval. It reverses PWM partway through a gap, where a design that kept the old count, or turned on the stale side, would shorten the new gap or cause overlap. It also applies shutdown and supply loss during both conduction and deadtime, then releases them. A design that resumed directly into an ON state would skip the full gap that must follow release.

// File: rtl/hbdt_pkg.sv
package hbdt_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_DEAD_HI = 3'd1,
        ST_HI_ON   = 3'd2,
        ST_DEAD_LO = 3'd3,
        ST_LO_ON   = 3'd4
    } hb_state_e;

    localparam int NUM_PRESETS = 4;
    localparam int MODE_W      = 3;

    // Nanoseconds to clock cycles, rounded to nearest, never below one.
    function automatic int ns_to_cycles(input int ns, input int clk_mhz);
        int c;
        c = (ns * clk_mhz + 500) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/hbdt_mode_decode.sv
module hbdt_mode_decode
    import hbdt_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int CYC_A = 3,
    parameter int CYC_B = 5,
    parameter int CYC_C = 7,
    parameter int CYC_D = 9
) (
    input  logic [MODE_W-1:0] mode_sel,
    output logic              shutdown,
    output logic [CNT_W-1:0]  reload_val
);
    localparam int CYC_ARR [NUM_PRESETS] = '{CYC_A, CYC_B, CYC_C, CYC_D};

    logic [CNT_W-1:0] preset_tbl [NUM_PRESETS];
    logic [1:0]       preset_idx;

    // Timer counts down to zero, so the stored value is one below the cycle count.
    for (genvar gi = 0; gi < NUM_PRESETS; gi++) begin : g_preset
        assign preset_tbl[gi] = CNT_W'(CYC_ARR[gi] - 1);
    end

    always_comb begin
        shutdown   = (mode_sel == '0);
        preset_idx = 2'd0;
        if (mode_sel >= MODE_W'(4))      preset_idx = 2'd3;
        else if (mode_sel == MODE_W'(3)) preset_idx = 2'd2;
        else if (mode_sel == MODE_W'(2)) preset_idx = 2'd1;
        else                             preset_idx = 2'd0;
        reload_val = preset_tbl[preset_idx];
    end

endmodule

// File: rtl/hbdt_dt_timer.sv
module hbdt_dt_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // R3
    preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (load_val != '0)) |=> !expired);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && expired) |=> expired);

endmodule

// File: rtl/hbdt_fsm.sv
module hbdt_fsm
    import hbdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwm,
    input  logic halt,
    input  logic expired,
    output logic load,
    output logic hs_en,
    output logic ls_en
);
    hb_state_e state_q, state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_nxt;
    end

    // Next-state and timer reload
    always_comb begin
        state_nxt = state_q;
        load      = 1'b0;
        if (halt) begin
            state_nxt = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    load      = 1'b1;
                    state_nxt = pwm ? ST_DEAD_HI : ST_DEAD_LO;
                end
                ST_DEAD_HI: begin
                    if (!pwm) begin
                        load      = 1'b1;
                        state_nxt = ST_DEAD_LO;
                    end else if (expired) begin
                        state_nxt = ST_HI_ON;
                    end
                end
                ST_HI_ON: begin
                    if (!pwm) begin
                        load      = 1'b1;
                        state_nxt = ST_DEAD_LO;
                    end
                end
                ST_DEAD_LO: begin
                    if (pwm) begin
                        load      = 1'b1;
                        state_nxt = ST_DEAD_HI;
                    end else if (expired) begin
                        state_nxt = ST_LO_ON;
                    end
                end
                ST_LO_ON: begin
                    if (pwm) begin
                        load      = 1'b1;
                        state_nxt = ST_DEAD_HI;
                    end
                end
                default: state_nxt = ST_OFF;
            endcase
        end
    end

    // Registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_en <= 1'b0;
            ls_en <= 1'b0;
        end else begin
            hs_en <= (state_nxt == ST_HI_ON);
            ls_en <= (state_nxt == ST_LO_ON);
        end
    end

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R5
    halt_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!hs_en && !ls_en));

    // R2
    hs_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> ($past(pwm) && !$past(halt)));

    // R2
    ls_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_en |-> (!$past(pwm) && !$past(halt)));

    // R3
    hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> !$past(ls_en));

    // R3
    ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> !$past(hs_en));

endmodule

// File: rtl/hb_deadtime_gen.sv
module hb_deadtime_gen
    import hbdt_pkg::*;
#(
    parameter int CLK_MHZ = 200,
    parameter int DT_A_NS = 15,
    parameter int DT_B_NS = 25,
    parameter int DT_C_NS = 35,
    parameter int DT_D_NS = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_in,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              supply_ok,
    output logic              hs_en,
    output logic              ls_en
);
    localparam int CYC_A   = ns_to_cycles(DT_A_NS, CLK_MHZ);
    localparam int CYC_B   = ns_to_cycles(DT_B_NS, CLK_MHZ);
    localparam int CYC_C   = ns_to_cycles(DT_C_NS, CLK_MHZ);
    localparam int CYC_D   = ns_to_cycles(DT_D_NS, CLK_MHZ);
    localparam int CYC_MAX = max4(CYC_A, CYC_B, CYC_C, CYC_D);
    localparam int CNT_W   = (CYC_MAX < 2) ? 1 : $clog2(CYC_MAX);

    logic             shutdown;
    logic             halt;
    logic             load;
    logic             expired;
    logic [CNT_W-1:0] reload_val;

    hbdt_mode_decode #(
        .CNT_W (CNT_W),
        .CYC_A (CYC_A),
        .CYC_B (CYC_B),
        .CYC_C (CYC_C),
        .CYC_D (CYC_D)
    ) u_decode (
        .mode_sel   (mode_sel),
        .shutdown   (shutdown),
        .reload_val (reload_val)
    );

    assign halt = shutdown | ~supply_ok;

    hbdt_dt_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (reload_val),
        .expired  (expired)
    );

    hbdt_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwm     (pwm_in),
        .halt    (halt),
        .expired (expired),
        .load    (load),
        .hs_en   (hs_en),
        .ls_en   (ls_en)
    );

    // R6
    supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!hs_en && !ls_en));

endmodule

// File: tb/hb_deadtime_gen_tb.sv
`timescale 1ns/1ps
module hb_deadtime_gen_tb;

    typedef struct {
        logic  hs;
        logic  ls;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_in = 1'b0;
    logic [2:0] mode_sel = 3'd1;
    logic       supply_ok = 1'b1;
    logic       hs_en, ls_en;

    int   checks = 0;
    int   errors = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    hb_deadtime_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_in    (pwm_in),
        .mode_sel  (mode_sel),
        .supply_ok (supply_ok),
        .hs_en     (hs_en),
        .ls_en     (ls_en)
    );

    task automatic drive(input logic p, input logic [2:0] m, input logic s);
        @(negedge clk);
        pwm_in    = p;
        mode_sel  = m;
        supply_ok = s;
    endtask

    task automatic run(input logic hs, input logic ls, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.hs = hs; e.ls = ls; e.tag = tag;
            q.push_back(e);
        end
    endtask

    task automatic drain();
        wait (q.size() == 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Monitor: samples 2 ns after each rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (hs_en !== e.hs || ls_en !== e.ls) begin
                    errors++;
                    $display("FAIL %s: hs_en/ls_en actual %b/%b expected %b/%b at %0t",
                             e.tag, hs_en, ls_en, e.hs, e.ls, $time);
                end
            end
            if (rst_n) begin
                checks++;
                if (hs_en === 1'b1 && ls_en === 1'b1) begin
                    errors++;
                    $display("FAIL R10: hs_en/ls_en actual 1/1 expected not both high at %0t", $time);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual run still active, expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        run(0, 0, 3, "R1");
        drain();
        @(negedge clk);
        rst_n = 1'b1;
        // R7: first turn-on after reset waits a full 3-cycle gap
        run(0, 0, 3, "R7");
        run(0, 1, 2, "R2");
        drain();

        // R3: rising edge, preset code 1 -> 3 cycles
        drive(1, 3'd1, 1);
        run(0, 0, 3, "R3");
        run(1, 0, 3, "R2");
        drain();
        // R3: falling edge, same gap
        drive(0, 3'd1, 1);
        run(0, 0, 3, "R3");
        run(0, 1, 2, "R3");
        drain();

        // R8: mode change alone changes nothing
        drive(0, 3'd2, 1);
        run(0, 1, 3, "R8");
        drain();
        // R4: code 2 -> 5 cycles
        drive(1, 3'd2, 1);
        run(0, 0, 5, "R4");
        run(1, 0, 2, "R4");
        drain();
        // R4: code 3 -> 7 cycles
        drive(0, 3'd3, 1);
        run(0, 0, 7, "R4");
        run(0, 1, 2, "R4");
        drain();
        // R4: code 4 -> 9 cycles
        drive(1, 3'd4, 1);
        run(0, 0, 9, "R4");
        run(1, 0, 2, "R4");
        drain();
        // R4: code 7 also -> 9 cycles
        drive(0, 3'd7, 1);
        run(0, 0, 9, "R4");
        run(0, 1, 2, "R4");
        drain();

        // R8: mode change inside a running gap keeps the latched preset
        drive(1, 3'd1, 1);
        run(0, 0, 1, "R8");
        drain();
        drive(1, 3'd4, 1);
        run(0, 0, 2, "R8");
        run(1, 0, 2, "R8");
        drain();

        // R9: reversal during a gap restarts a full gap the other way
        drive(0, 3'd1, 1);
        run(0, 0, 2, "R9");
        drain();
        drive(1, 3'd1, 1);
        run(0, 0, 3, "R9");
        run(1, 0, 2, "R9");
        drain();

        // R5: shutdown while high side conducts
        drive(1, 3'd0, 1);
        run(0, 0, 4, "R5");
        drain();
        drive(0, 3'd0, 1);
        run(0, 0, 3, "R5");
        drain();
        // R7: release from shutdown waits a full 5-cycle gap
        drive(0, 3'd2, 1);
        run(0, 0, 5, "R7");
        run(0, 1, 2, "R7");
        drain();

        // R6: supply loss
        drive(0, 3'd2, 0);
        run(0, 0, 3, "R6");
        drain();
        drive(1, 3'd2, 0);
        run(0, 0, 3, "R6");
        drain();
        // R7: supply return waits a full gap
        drive(1, 3'd2, 1);
        run(0, 0, 5, "R7");
        run(1, 0, 2, "R7");
        drain();

        // R5: shutdown in the middle of a gap
        drive(0, 3'd2, 1);
        run(0, 0, 2, "R5");
        drain();
        drive(0, 3'd0, 1);
        run(0, 0, 3, "R5");
        drain();
        drive(0, 3'd1, 1);
        run(0, 0, 3, "R7");
        run(0, 1, 2, "R7");
        drain();

        repeat (2) @(posedge clk);
        summary();
        $finish;
    end

endmodule